// File: doc/BRIEF.md
# Streamed AEAD coprocessor bridge with result queue

This block connects a word-serial authenticated-encryption engine to a 32-bit APB bus. Software loads the key, the public nonce and the two message lengths into registers, then issues a start. Each later write to the data-in port goes straight to the engine in the same bus cycle; the bridge holds no input buffer. Every word the engine produces (ciphertext during the payload phase, then the authentication tag words) is stored in an on-chip result queue, and software drains that queue through a read-and-pop data-out register.

The engine cannot take data while it runs its initial mixing rounds or its closing rounds. During those periods software polls a status register, which reports busy, waiting, input-ready, done, an overrun error and the queue fill level. A long message has to be sent in installments: software streams at most one queue's worth of payload, reads the results, and then continues. The engine in this project is a small behavioural model with a fixed keystream and tag rule, so that the bridge can be checked on its own.

Top module: `aead_outq_wrap`

## Requirements
- R1: After reset, STATUS reads zero: busy (bit 0), waiting (bit 1), done (bit 2), input-ready (bit 3), overrun error (bit 4) and fill level (bits 15:8) are all clear, and a DOUT read returns zero.
- R2: A CTRL write with bit 0 set, while the engine is idle or done, starts a run. For INIT_CYC cycles after that write, busy and waiting are set and input-ready is clear; then input-ready rises.
- R3: The first ADLEN words written to DIN (offset 0x30) are taken by the engine as associated data and put nothing into the result queue.
- R4: Payload word i (counted from 0) written to DIN after the associated data puts key word 0 XOR nonce word 1 XOR (i+1)*0x9E3779B9 (mod 2^32) XOR the word into the queue, and the fill level goes up by one.
- R5: A read of DOUT (offset 0x34) returns the oldest queued word and removes it; a read of DOUT with an empty queue returns zero and changes nothing.
- R6: A DIN write while input-ready is clear drops the word and sets the overrun bit, which stays set until a STATUS write with bit 4 set; a STATUS write with bit 4 clear leaves it.
- R7: When the queue is full, the engine holds its pending output word and clears input-ready; no word is lost, and the held word enters the queue once software makes room.
- R8: After the last data word, the engine waits FIN_CYC cycles, then queues four tag words, word j being key word j XOR nonce word j XOR the XOR of all accepted data words; done (bit 2) rises only once the last tag word is queued.
- R9: With ADLEN and PTLEN both zero, a run goes straight from the initial wait to the closing wait and yields only the four tag words.
- R10: A CTRL write while a run is busy has no effect on that run or on the stored mode.
- R11: With mode (CTRL bit 1) set at start, every tag word is additionally inverted.
- R12: KEY words (0x10 to 0x1C), NONCE words (0x20 to 0x2C), ADLEN (0x08) and PTLEN (0x0C) read back as written; PREADY is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high, no wait states |

## Verification
A payload word accepted on the access edge of its DIN write reaches the queue one edge later, so any STATUS read issued after that write already shows the new level, and the bench reads STATUS only after the write has finished. The initial wait ends INIT_CYC edges after the start edge; the bench counts cycles from the start write to the first STATUS read that shows input-ready and accepts a window of one bus transfer around that count. The closing wait and tag output depend on queue space, so the bench polls the done bit before it drains the tag, and it samples read data in the middle of the access phase, before the edge that pops.

// File: rtl/aead_wrap_pkg.sv
package aead_wrap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_INIT, PH_AD, PH_PT, PH_FIN, PH_TAG, PH_DONE
  } phase_e;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_STATUS = 8'h04;
  localparam logic [7:0] A_ADLEN  = 8'h08;
  localparam logic [7:0] A_PTLEN  = 8'h0C;
  localparam logic [7:0] A_KEY0   = 8'h10;
  localparam logic [7:0] A_NONCE0 = 8'h20;
  localparam logic [7:0] A_DIN    = 8'h30;
  localparam logic [7:0] A_DOUT   = 8'h34;

  localparam int ST_BUSY  = 0;
  localparam int ST_WAIT  = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_READY = 3;
  localparam int ST_ERR   = 4;

  localparam logic [31:0] KS_STEP = 32'h9E3779B9;

  // keystream word for payload index idx
  function automatic logic [31:0] ks_word(input logic [31:0] idx);
    return (idx + 32'd1) * KS_STEP;
  endfunction

  // tag word from running XOR, key/nonce words and mode
  function automatic logic [31:0] tag_word(input logic [31:0] acc,
                                           input logic [31:0] k,
                                           input logic [31:0] n,
                                           input logic        inv);
    return acc ^ k ^ n ^ {32{inv}};
  endfunction

  // index of a 4-word register bank, -1 when the address is outside it
  function automatic int bank_idx(input logic [7:0] addr, input logic [7:0] base);
    for (int i = 0; i < 4; i++)
      if (addr == base + 8'(4 * i)) return i;
    return -1;
  endfunction

endpackage

// File: rtl/outq_fifo.sv
module outq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign rdata = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/aead_core_stub.sv
module aead_core_stub
  import aead_wrap_pkg::*;
#(
  parameter int INIT_CYC  = 12,
  parameter int FIN_CYC   = 6,
  parameter int LENW      = 16,
  parameter int TAG_WORDS = 4,
  localparam int WCW      = $clog2(INIT_CYC + FIN_CYC + 1),
  localparam int TIW      = $clog2(TAG_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode,
  input  logic [127:0]    key,
  input  logic [127:0]    nonce,
  input  logic [LENW-1:0] adlen,
  input  logic [LENW-1:0] ptlen,
  input  logic [31:0]     din,
  input  logic            din_valid,
  output logic            din_ready,
  output logic            out_valid,
  output logic [31:0]     out_data,
  input  logic            out_ready,
  output logic            busy,
  output logic            waiting,
  output logic            done
);

  phase_e          phase;
  logic [WCW-1:0]  wcnt;
  logic [LENW-1:0] cnt;
  logic [TIW-1:0]  tagi;
  logic [31:0]     acc;
  logic            mode_q;
  logic            ov;
  logic [31:0]     od;

  logic            accept;
  logic [LENW-1:0] cnt_nx;
  logic            can_start;

  assign din_ready = (phase == PH_AD) || (phase == PH_PT && !ov);
  assign accept    = din_valid && din_ready;
  assign cnt_nx    = cnt + {{(LENW-1){1'b0}}, 1'b1};
  assign waiting   = (phase == PH_INIT) || (phase == PH_FIN);
  assign can_start = (phase == PH_IDLE || phase == PH_DONE) && !ov;
  assign busy      = !can_start;
  assign done      = (phase == PH_DONE) && !ov;
  assign out_valid = ov;
  assign out_data  = od;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      wcnt   <= '0;
      cnt    <= '0;
      tagi   <= '0;
      acc    <= '0;
      mode_q <= 1'b0;
      ov     <= 1'b0;
      od     <= '0;
    end else begin
      if (ov && out_ready) ov <= 1'b0;
      unique case (phase)
        PH_IDLE, PH_DONE: begin
          if (start && can_start) begin
            phase  <= PH_INIT;
            wcnt   <= '0;
            cnt    <= '0;
            acc    <= '0;
            mode_q <= mode;
          end
        end
        PH_INIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCW'(INIT_CYC - 1)) begin
            wcnt <= '0;
            if (adlen != '0)      phase <= PH_AD;
            else if (ptlen != '0) phase <= PH_PT;
            else                  phase <= PH_FIN;
          end
        end
        PH_AD: begin
          if (accept) begin
            acc <= acc ^ din;
            cnt <= cnt_nx;
            if (cnt_nx == adlen) begin
              cnt   <= '0;
              phase <= (ptlen != '0) ? PH_PT : PH_FIN;
            end
          end
        end
        PH_PT: begin
          if (accept) begin
            acc <= acc ^ din;
            ov  <= 1'b1;
            od  <= din ^ key[31:0] ^ nonce[63:32] ^ ks_word(32'(cnt));
            cnt <= cnt_nx;
            if (cnt_nx == ptlen) begin
              cnt   <= '0;
              phase <= PH_FIN;
            end
          end
        end
        PH_FIN: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCW'(FIN_CYC - 1)) begin
            wcnt  <= '0;
            tagi  <= '0;
            phase <= PH_TAG;
          end
        end
        PH_TAG: begin
          if (!ov) begin
            ov   <= 1'b1;
            od   <= tag_word(acc, key[32*tagi +: 32], nonce[32*tagi +: 32], mode_q);
            tagi <= tagi + 1'b1;
            if (tagi == TIW'(TAG_WORDS - 1)) phase <= PH_DONE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r2_no_ready_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !din_ready);
  a_r7_hold_stalled_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));

endmodule

// File: rtl/aead_outq_wrap.sv
module aead_outq_wrap
  import aead_wrap_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int INIT_CYC = 12,
  parameter int FIN_CYC  = 6,
  parameter int LENW     = 16,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready
);

  logic [127:0]    key_q, nonce_q;
  logic [LENW-1:0] adlen_q, ptlen_q;
  logic            mode_q, err_q;

  logic wr_acc, rd_acc;
  logic start_req, din_valid, drop_evt, pop_req, push;
  logic din_ready, out_valid, out_ready, busy, waiting, done;
  logic [31:0] out_data, q_rdata;
  logic q_full, q_empty;
  logic [LW-1:0] q_level;
  logic [31:0] status_w;

  assign pready    = 1'b1;
  assign wr_acc    = psel && penable && pwrite;
  assign rd_acc    = psel && penable && !pwrite;
  assign start_req = wr_acc && (paddr == A_CTRL) && pwdata[0] && !busy;
  assign din_valid = wr_acc && (paddr == A_DIN);
  assign drop_evt  = din_valid && !din_ready;
  assign pop_req   = rd_acc && (paddr == A_DOUT) && !q_empty;
  assign out_ready = !q_full;
  assign push      = out_valid && out_ready;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      key_q   <= '0;
      nonce_q <= '0;
      adlen_q <= '0;
      ptlen_q <= '0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_acc) begin
        for (int i = 0; i < 4; i++) begin
          if (bank_idx(paddr, A_KEY0) == i)   key_q[32*i +: 32]   <= pwdata;
          if (bank_idx(paddr, A_NONCE0) == i) nonce_q[32*i +: 32] <= pwdata;
        end
        if (paddr == A_ADLEN) adlen_q <= pwdata[LENW-1:0];
        if (paddr == A_PTLEN) ptlen_q <= pwdata[LENW-1:0];
        if (paddr == A_STATUS && pwdata[ST_ERR]) err_q <= 1'b0;
      end
      if (start_req) mode_q <= pwdata[1];
      if (drop_evt)  err_q  <= 1'b1;
    end
  end

  aead_core_stub #(
    .INIT_CYC (INIT_CYC),
    .FIN_CYC  (FIN_CYC),
    .LENW     (LENW),
    .TAG_WORDS(4)
  ) u_core (
    .clk      (pclk),
    .rst_n    (presetn),
    .start    (start_req),
    .mode     (pwdata[1]),
    .key      (key_q),
    .nonce    (nonce_q),
    .adlen    (adlen_q),
    .ptlen    (ptlen_q),
    .din      (pwdata),
    .din_valid(din_valid),
    .din_ready(din_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ready(out_ready),
    .busy     (busy),
    .waiting  (waiting),
    .done     (done)
  );

  outq_fifo #(.W(32), .DEPTH(DEPTH)) u_q (
    .clk  (pclk),
    .rst_n(presetn),
    .push (push),
    .wdata(out_data),
    .pop  (pop_req),
    .rdata(q_rdata),
    .full (q_full),
    .empty(q_empty),
    .level(q_level)
  );

  always_comb begin
    status_w = '0;
    status_w[ST_BUSY]  = busy;
    status_w[ST_WAIT]  = waiting;
    status_w[ST_DONE]  = done;
    status_w[ST_READY] = din_ready;
    status_w[ST_ERR]   = err_q;
    status_w[15:8]     = 8'(q_level);
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_CTRL)        prdata = {30'b0, mode_q, 1'b0};
    else if (paddr == A_STATUS) prdata = status_w;
    else if (paddr == A_ADLEN)  prdata = 32'(adlen_q);
    else if (paddr == A_PTLEN)  prdata = 32'(ptlen_q);
    else if (paddr == A_DOUT)   prdata = q_empty ? 32'b0 : q_rdata;
    else begin
      for (int i = 0; i < 4; i++) begin
        if (bank_idx(paddr, A_KEY0) == i)   prdata = key_q[32*i +: 32];
        if (bank_idx(paddr, A_NONCE0) == i) prdata = nonce_q[32*i +: 32];
      end
    end
  end

  a_r6_drop_sets_err: assert property (@(posedge pclk) disable iff (!presetn)
    drop_evt |=> err_q);
  a_r5_empty_read_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && paddr == A_DOUT && q_empty) |-> (prdata == 32'b0));
  a_r10_mode_kept_busy: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(busy) && busy) |-> $stable(mode_q));

endmodule

// File: tb/aead_outq_wrap_tb.sv
module aead_outq_wrap_tb;

  localparam int DEPTH    = 64;
  localparam int INIT_CYC = 12;
  localparam int FIN_CYC  = 6;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] K [4] = '{32'h0123_4567, 32'h89AB_CDEF, 32'h1357_9BDF, 32'h2468_ACE0};
  logic [31:0] N [4] = '{32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0BAD_C0DE, 32'hFEED_FACE};

  always #5 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  aead_outq_wrap #(.DEPTH(DEPTH), .INIT_CYC(INIT_CYC), .FIN_CYC(FIN_CYC)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #2 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic poll(input int bitn, output logic [31:0] st);
    for (int i = 0; i < 400; i++) begin
      apb_rd(8'h04, st);
      if (st[bitn]) return;
    end
  endtask

  function automatic logic [31:0] ct_of(input logic [31:0] pt, input int idx);
    logic [31:0] ks = 32'h0;
    for (int i = 0; i <= idx; i++) ks = ks + 32'h9E3779B9;
    return pt ^ K[0] ^ N[1] ^ ks;
  endfunction

  task automatic load(input int adl, input int ptl);
    for (int i = 0; i < 4; i++) begin
      apb_wr(8'h10 + 8'(4*i), K[i]);
      apb_wr(8'h20 + 8'(4*i), N[i]);
    end
    apb_wr(8'h08, 32'(adl));
    apb_wr(8'h0C, 32'(ptl));
  endtask

  task automatic check_tag(input logic [31:0] acc, input logic inv, input string req);
    logic [31:0] d;
    for (int j = 0; j < 4; j++) begin
      apb_rd(8'h34, d);
      chk(req, d, acc ^ K[j] ^ N[j] ^ {32{inv}});
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    apb_rd(8'h04, d); chk("R1 status after reset", d, 32'h0);
    apb_rd(8'h34, d); chk("R1 dout after reset", d, 32'h0);
    chk("R12 pready", 32'(pready), 32'h1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    load(2, 3);
    for (int i = 0; i < 4; i++) begin
      apb_rd(8'h10 + 8'(4*i), d); chk("R12 key readback", d, K[i]);
      apb_rd(8'h20 + 8'(4*i), d); chk("R12 nonce readback", d, N[i]);
    end
    apb_rd(8'h08, d); chk("R12 adlen readback", d, 32'd2);
    apb_rd(8'h0C, d); chk("R12 ptlen readback", d, 32'd3);
  endtask

  task automatic t_basic;
    logic [31:0] st, d, acc;
    int c0, el;
    logic [31:0] ad [2] = '{32'h1111_0001, 32'h2222_0002};
    logic [31:0] pt [3] = '{32'hA5A5_0000, 32'h5A5A_1111, 32'h0000_FFFF};
    acc = 32'h0;
    apb_wr(8'h00, 32'h1);
    c0 = cyc;
    apb_rd(8'h04, st);
    chk("R2 busy+wait, not ready", {28'b0, st[3:0]}, 32'h3);
    apb_wr(8'h30, 32'h7777_7777);             // dropped: engine waiting
    poll(3, st);
    el = cyc - c0;
    chk("R2 wait length in window", 32'((el >= INIT_CYC - 1) && (el <= INIT_CYC + 3)), 32'h1);
    chk("R6 overrun set by early write", 32'(st[4]), 32'h1);
    foreach (ad[i]) begin apb_wr(8'h30, ad[i]); acc ^= ad[i]; end
    apb_rd(8'h04, st);
    chk("R3 AD puts nothing in queue", 32'(st[15:8]), 32'h0);
    apb_wr(8'h00, 32'h3);                     // ignored: busy
    apb_rd(8'h00, d);
    chk("R10 mode unchanged while busy", d, 32'h0);
    foreach (pt[i]) begin apb_wr(8'h30, pt[i]); acc ^= pt[i]; end
    apb_rd(8'h04, st);
    chk("R4 level after payload", 32'(st[15:8]), 32'h3);
    poll(2, st);
    chk("R8 done with 7 words queued", 32'(st[15:8]), 32'h7);
    foreach (pt[i]) begin
      apb_rd(8'h34, d); chk("R4 ciphertext word", d, ct_of(pt[i], i));
    end
    check_tag(acc, 1'b0, "R8 tag word");
    apb_rd(8'h34, d); chk("R5 empty read is zero", d, 32'h0);
    apb_rd(8'h04, st);
    chk("R5 level stays zero", 32'(st[15:8]), 32'h0);
    apb_wr(8'h04, 32'h0);
    apb_rd(8'h04, st); chk("R6 write 0 keeps error", 32'(st[4]), 32'h1);
    apb_wr(8'h04, 32'h10);
    apb_rd(8'h04, st); chk("R6 write 1 clears error", 32'(st[4]), 32'h0);
  endtask

  task automatic t_mode;
    logic [31:0] st, acc;
    load(1, 1);
    apb_wr(8'h00, 32'h3);
    poll(3, st);
    apb_wr(8'h30, 32'h0F0F_0F0F);
    poll(3, st);
    apb_wr(8'h30, 32'h1234_5678);
    acc = 32'h0F0F_0F0F ^ 32'h1234_5678;
    poll(2, st);
    chk("R11 ct queued before tag", 32'(st[15:8]), 32'h5);
    begin
      logic [31:0] d;
      apb_rd(8'h34, d); chk("R4 ciphertext mode1", d, ct_of(32'h1234_5678, 0));
    end
    check_tag(acc, 1'b1, "R11 inverted tag");
  endtask

  task automatic t_zero;
    logic [31:0] st;
    load(0, 0);
    apb_wr(8'h00, 32'h1);
    poll(2, st);
    chk("R9 only tag queued", 32'(st[15:8]), 32'h4);
    check_tag(32'h0, 1'b0, "R9 tag empty message");
  endtask

  task automatic t_full;
    logic [31:0] st, d, acc;
    acc = 32'h0;
    load(0, 70);
    apb_wr(8'h00, 32'h1);
    for (int i = 0; i < 65; i++) begin
      poll(3, st);
      apb_wr(8'h30, 32'h4000_0000 + 32'(i));
      acc ^= 32'h4000_0000 + 32'(i);
    end
    apb_rd(8'h04, st);
    chk("R7 queue full", 32'(st[15:8]), 32'd64);
    chk("R7 not ready while stalled", 32'(st[3]), 32'h0);
    for (int i = 0; i < 64; i++) begin
      apb_rd(8'h34, d);
      if (i == 0 || i == 63) chk("R7 drained word", d, ct_of(32'h4000_0000 + 32'(i), i));
    end
    apb_rd(8'h04, st);
    chk("R7 held word entered queue", 32'(st[15:8]), 32'h1);
    for (int i = 65; i < 70; i++) begin
      poll(3, st);
      apb_wr(8'h30, 32'h4000_0000 + 32'(i));
      acc ^= 32'h4000_0000 + 32'(i);
    end
    poll(2, st);
    for (int i = 64; i < 70; i++) begin
      apb_rd(8'h34, d); chk("R7 no word lost", d, ct_of(32'h4000_0000 + 32'(i), i));
    end
    check_tag(acc, 1'b0, "R8 tag long message");
  endtask

  task automatic finish_run;
    if (finished) return;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset;
    t_regs;
    t_basic;
    t_mode;
    t_zero;
    t_full;
    finish_run;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

endmodule